// File: doc/BRIEF.md
# Aged Discharge-Rate Gain Calculator

This block computes the effective discharge-rate compensation gain that a capacity-compensation stage applies. It takes three packed configuration bytes (discharge compensation, temperature compensation, and an age byte), two fixed-mode flags that replace two of those bytes with hard-wired values, and a charge-cycle count. On a start strobe it decodes the bytes and returns two results: a gain that grows with cycle count, and the offset threshold below which no compensation is applied.

The base gain is five bits in units of 1/256. The aged gain is `G * (1 + T * (N/16) * A/32)`, evaluated as `G + floor(G*T*A*N / 512)`. Here T is the temperature gain, A the 2-bit age factor and N the cycle count. The product with the cycle count comes from a sequential shift-add multiplier that retires one cycle-count bit per clock. A result therefore takes a fixed number of clocks and is reported by a one-cycle done pulse. Both outputs then hold until the next accepted start.

Top module: `agegain_top`

## Requirements
- R1: The discharge-compensation byte carries the base gain G in bits 7..3 and the offset code in bits 2..0. The threshold output equals offset code × 32, which is in units of C/256, so each code step is C/8.
- R2: When `fix_dc_i` is 1 at start, the discharge-compensation byte is replaced by 0x6C. This gives G = 13 and a threshold of 128 (C/2).
- R3: The temperature gain T is bits 7..4 of the temperature-compensation byte. When `fix_tc_i` is 1 at start, that byte is replaced by 0x46, which gives T = 4.
- R4: The age factor A is bits 7..6 of the age byte. Bits 5..0 of that byte have no effect on either output.
- R5: The aged gain equals G + floor(G×T×A×N / 512), where N is `cycles_i`. The intermediate product is held in at least 24 bits.
- R6: When A = 0, the aged gain equals G for every cycle count.
- R7: A result above 65535 is reported as 65535 instead of wrapping.
- R8: `done_o` is high for exactly one cycle. It rises on the CYC_W+1-th rising edge after the edge that accepted the start.
- R9: A start while a computation is running is ignored. Inputs are captured only at the accepted start, and only one done pulse follows.
- R10: Between done pulses, both outputs hold their values whatever the inputs do, until a new start is accepted.
- R11: After reset, `done_o`, the aged gain and the threshold are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| fix_dc_i | input | 1 | Use the hard-wired discharge-compensation byte |
| fix_tc_i | input | 1 | Use the hard-wired temperature-compensation byte |
| dcomp_i | input | 8 | Discharge-compensation byte |
| tcomp_i | input | 8 | Temperature-compensation byte |
| agedv_i | input | 8 | Age byte (age factor in bits 7..6) |
| cycles_i | input | CYC_W | Charge-cycle count |
| aged_gain_o | output | OUT_W | Aged gain, units of 1/256, saturating |
| offset_thr_o | output | 8 | Offset threshold, units of C/256 |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions assume reset is applied before the first start. They also assume every start pulse is sampled on a clock edge with stable operands, since the block captures all configuration inputs and the cycle count only on the accepted edge. The stimulus changes inputs only on falling edges and holds each operand set steady through the accepting edge. Inputs are then changed deliberately during the run and after done, to show that they are captured only at the accepted start.

// File: rtl/agegain_pkg.sv
package agegain_pkg;

    localparam int GAIN_W   = 5;
    localparam int TGAIN_W  = 4;
    localparam int AGEF_W   = 2;
    localparam int OFF_W    = 3;
    localparam int COEF_W   = GAIN_W + TGAIN_W + AGEF_W;
    localparam int FRAC_SH  = 9;   // /16 for cycles and /32 for age factor
    localparam int THR_W    = 8;
    localparam int THR_SH   = 5;   // code * 32 = code * C/8 in C/256 units

    localparam logic [7:0] FIXED_DCOMP = 8'h6C;
    localparam logic [7:0] FIXED_TCOMP = 8'h46;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_FIN  = 2'd2
    } ag_state_e;

endpackage

// File: rtl/agegain_decode.sv
module agegain_decode
    import agegain_pkg::*;
(
    input  logic              fix_dc_i,
    input  logic              fix_tc_i,
    input  logic [7:0]        dcomp_i,
    input  logic [7:0]        tcomp_i,
    input  logic [7:0]        agedv_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic [OFF_W-1:0]  offcode_o,
    output logic [TGAIN_W-1:0] tgain_o,
    output logic [AGEF_W-1:0] agef_o,
    output logic [COEF_W-1:0] coef_o
);

    logic [7:0] dsel;
    logic [7:0] tsel;

    always_comb begin
        dsel      = fix_dc_i ? FIXED_DCOMP : dcomp_i;
        tsel      = fix_tc_i ? FIXED_TCOMP : tcomp_i;
        gain_o    = dsel[7 -: GAIN_W];
        offcode_o = dsel[OFF_W-1:0];
        tgain_o   = tsel[7 -: TGAIN_W];
        agef_o    = agedv_i[7 -: AGEF_W];
        // small constant-width coefficient: G * T * A
        coef_o    = COEF_W'(gain_o) * COEF_W'(tgain_o) * COEF_W'(agef_o);
    end

endmodule

// File: rtl/agegain_mul.sv
module agegain_mul
    import agegain_pkg::*;
#(
    parameter int CYC_W = 16,
    localparam int PROD_W = COEF_W + CYC_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [COEF_W-1:0] mcand_i,
    input  logic [CYC_W-1:0]  mplier_i,
    output logic [PROD_W-1:0] prod_o
);

    typedef struct packed {
        logic [PROD_W-1:0] acc;
        logic [PROD_W-1:0] mcand;
        logic [CYC_W-1:0]  mplier;
    } mul_s;

    mul_s m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (load_i) begin
            m_d.acc    = '0;
            m_d.mcand  = PROD_W'(mcand_i);
            m_d.mplier = mplier_i;
        end else if (step_i) begin
            if (m_q.mplier[0]) begin
                m_d.acc = m_q.acc + m_q.mcand;
            end
            m_d.mcand  = m_q.mcand << 1;
            m_d.mplier = m_q.mplier >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign prod_o = m_q.acc;

endmodule

// File: rtl/agegain_sat.sv
module agegain_sat
    import agegain_pkg::*;
#(
    parameter int PROD_W = 27,
    parameter int OUT_W  = 16,
    localparam int SH_W  = PROD_W - FRAC_SH,
    localparam int SUM_W = ((SH_W > GAIN_W) ? SH_W : GAIN_W) + 1
)(
    input  logic [GAIN_W-1:0] base_i,
    input  logic [PROD_W-1:0] prod_i,
    output logic [OUT_W-1:0]  res_o
);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(base_i) + SUM_W'(prod_i >> FRAC_SH);
    end

    generate
        if (SUM_W > OUT_W) begin : g_clip
            always_comb begin
                res_o = (|sum[SUM_W-1:OUT_W]) ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
            end
        end else begin : g_wide
            always_comb begin
                res_o = OUT_W'(sum);
            end
        end
    endgenerate

endmodule

// File: rtl/agegain_top.sv
module agegain_top
    import agegain_pkg::*;
#(
    parameter int CYC_W = 16,
    parameter int OUT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             fix_dc_i,
    input  logic             fix_tc_i,
    input  logic [7:0]       dcomp_i,
    input  logic [7:0]       tcomp_i,
    input  logic [7:0]       agedv_i,
    input  logic [CYC_W-1:0] cycles_i,
    output logic [OUT_W-1:0] aged_gain_o,
    output logic [THR_W-1:0] offset_thr_o,
    output logic             done_o
);

    localparam int PROD_W = COEF_W + CYC_W;
    localparam int CNT_W  = $clog2(CYC_W + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(CYC_W - 1);

    typedef struct packed {
        ag_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [GAIN_W-1:0] gain;
        logic [OFF_W-1:0]  offcode;
        logic [AGEF_W-1:0] agef;
        logic [OUT_W-1:0]  aged;
        logic [THR_W-1:0]  thr;
        logic              done;
    } top_s;

    top_s r_d, r_q;

    logic [GAIN_W-1:0]  dec_gain;
    logic [OFF_W-1:0]   dec_off;
    logic [TGAIN_W-1:0] dec_tgain;
    logic [AGEF_W-1:0]  dec_agef;
    logic [COEF_W-1:0]  dec_coef;
    logic [PROD_W-1:0]  prod;
    logic [OUT_W-1:0]   sat_res;
    logic               accept;
    logic               mul_step;

    // signals exposed to the bound checker
    logic               busy;
    logic [GAIN_W-1:0]  base_gain;
    logic [AGEF_W-1:0]  age_fac;

    agegain_decode u_dec (
        .fix_dc_i  (fix_dc_i),
        .fix_tc_i  (fix_tc_i),
        .dcomp_i   (dcomp_i),
        .tcomp_i   (tcomp_i),
        .agedv_i   (agedv_i),
        .gain_o    (dec_gain),
        .offcode_o (dec_off),
        .tgain_o   (dec_tgain),
        .agef_o    (dec_agef),
        .coef_o    (dec_coef)
    );

    agegain_mul #(.CYC_W(CYC_W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .step_i   (mul_step),
        .mcand_i  (dec_coef),
        .mplier_i (cycles_i),
        .prod_o   (prod)
    );

    agegain_sat #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_sat (
        .base_i (r_q.gain),
        .prod_i (prod),
        .res_o  (sat_res)
    );

    always_comb begin
        accept   = start_i && (r_q.state == ST_IDLE);
        mul_step = (r_q.state == ST_MUL);
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.state   = ST_MUL;
                    r_d.cnt     = '0;
                    r_d.gain    = dec_gain;
                    r_d.offcode = dec_off;
                    r_d.agef    = dec_agef;
                end
            end
            ST_MUL: begin
                if (r_q.cnt == LAST_STEP) begin
                    r_d.state = ST_FIN;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_FIN: begin
                r_d.aged  = sat_res;
                r_d.thr   = THR_W'(r_q.offcode) << THR_SH;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign aged_gain_o  = r_q.aged;
    assign offset_thr_o = r_q.thr;
    assign done_o       = r_q.done;
    assign busy         = (r_q.state != ST_IDLE);
    assign base_gain    = r_q.gain;
    assign age_fac      = r_q.agef;

endmodule

// File: rtl/agegain_chk.sv
module agegain_chk
    import agegain_pkg::*;
#(
    parameter int OUT_W = 16
)(
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic [OUT_W-1:0]  aged_o,
    input logic [THR_W-1:0]  thr_o,
    input logic              busy_i,
    input logic [GAIN_W-1:0] base_i,
    input logic [AGEF_W-1:0] agef_i
);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !done_o);

    a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(aged_o) && $stable(thr_o)));

    a_r6_zero_age: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && agef_i == '0) |-> (aged_o == OUT_W'(base_i)));

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (aged_o >= OUT_W'(base_i)));

    a_r1_thr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (thr_o[THR_SH-1:0] == '0));

endmodule

bind agegain_top agegain_chk #(.OUT_W(OUT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_o (done_o),
    .aged_o (aged_gain_o),
    .thr_o  (offset_thr_o),
    .busy_i (busy),
    .base_i (base_gain),
    .agef_i (age_fac)
);

// File: tb/sim_agegain_top.sv
`timescale 1ns/1ps
module sim_agegain_top;

    localparam int CYC_W = 16;
    localparam int OUT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             fix_dc_i = 1'b0;
    logic             fix_tc_i = 1'b0;
    logic [7:0]       dcomp_i = '0;
    logic [7:0]       tcomp_i = '0;
    logic [7:0]       agedv_i = '0;
    logic [CYC_W-1:0] cycles_i = '0;
    logic [OUT_W-1:0] aged_gain_o;
    logic [7:0]       offset_thr_o;
    logic             done_o;

    int checks = 0;
    int errors = 0;
    int cyc_count = 0;
    int lat;

    always #10 clk = ~clk;

    agegain_top #(.CYC_W(CYC_W), .OUT_W(OUT_W)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint model(input bit fdc, input bit ftc, input logic [7:0] d,
                                     input logic [7:0] t, input logic [7:0] a, input longint n);
        longint g, tg, af, r;
        g  = fdc ? 13 : longint'(d[7:3]);
        tg = ftc ? 4 : longint'(t[7:4]);
        af = longint'(a[7:6]);
        r  = g + ((g * tg * af * n) >> 9);
        if (r > 65535) r = 65535;
        return r;
    endfunction

    function automatic longint thr_model(input bit fdc, input logic [7:0] d);
        return fdc ? 128 : longint'(d[2:0]) * 32;
    endfunction

    // runs one computation; returns latency in edges after the accepting edge
    task automatic run(input bit fdc, input bit ftc, input logic [7:0] d, input logic [7:0] t,
                       input logic [7:0] a, input logic [CYC_W-1:0] n, output int l);
        @(negedge clk);
        fix_dc_i = fdc; fix_tc_i = ftc; dcomp_i = d; tcomp_i = t; agedv_i = a; cycles_i = n;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        l = 0;
        do begin
            @(negedge clk);
            l++;
        end while (!done_o && l < 100);
    endtask

    task automatic t_reset();
        chk(done_o == 1'b0, "R11 done after reset", done_o, 0);
        chk(aged_gain_o == 0, "R11 gain after reset", aged_gain_o, 0);
        chk(offset_thr_o == 0, "R11 thr after reset", offset_thr_o, 0);
    endtask

    task automatic t_decode();
        run(0, 0, 8'hA5, 8'h30, 8'h00, 16'd500, lat);
        chk(aged_gain_o == 20, "R1 gain field", aged_gain_o, 20);
        chk(offset_thr_o == 160, "R1 threshold field", offset_thr_o, 160);
        chk(lat == CYC_W + 1, "R8 latency", lat, CYC_W + 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    endtask

    task automatic t_basic();
        longint e;
        e = model(0, 0, 8'h50, 8'h30, 8'h80, 100);
        run(0, 0, 8'h50, 8'h30, 8'h80, 16'd100, lat);
        chk(aged_gain_o == e, "R5 aged gain", aged_gain_o, e);
        chk(offset_thr_o == 0, "R1 zero offset", offset_thr_o, 0);
        e = model(0, 0, 8'hF9, 8'hB0, 8'h40, 16'd12345);
        run(0, 0, 8'hF9, 8'hB0, 8'h40, 16'd12345, lat);
        chk(aged_gain_o == e, "R5 aged gain pattern 2", aged_gain_o, e);
    endtask

    task automatic t_fixdc();
        run(1, 0, 8'hFF, 8'h20, 8'h40, 16'd512, lat);
        chk(aged_gain_o == 39, "R2 fixed discharge gain", aged_gain_o, 39);
        chk(offset_thr_o == 128, "R2 fixed discharge threshold", offset_thr_o, 128);
    endtask

    task automatic t_fixtc();
        run(0, 1, 8'h80, 8'hF0, 8'hC0, 16'd85, lat);
        chk(aged_gain_o == 47, "R3 fixed temperature gain", aged_gain_o, 47);
        run(0, 0, 8'h80, 8'hF0, 8'hC0, 16'd85, lat);
        chk(aged_gain_o == model(0, 0, 8'h80, 8'hF0, 8'hC0, 85), "R3 programmed temperature nibble",
            aged_gain_o, model(0, 0, 8'h80, 8'hF0, 8'hC0, 85));
    endtask

    task automatic t_lowbits();
        run(0, 0, 8'h88, 8'h10, 8'h40, 16'd1000, lat);
        chk(aged_gain_o == 50, "R4 age byte low bits clear", aged_gain_o, 50);
        run(0, 0, 8'h88, 8'h10, 8'h7F, 16'd1000, lat);
        chk(aged_gain_o == 50, "R4 age byte low bits set", aged_gain_o, 50);
    endtask

    task automatic t_agezero();
        run(0, 0, 8'hF8, 8'hF0, 8'h3F, 16'hFFFF, lat);
        chk(aged_gain_o == 31, "R6 zero age factor max cycles", aged_gain_o, 31);
        run(0, 1, 8'h48, 8'hF0, 8'h00, 16'd777, lat);
        chk(aged_gain_o == 9, "R6 zero age factor", aged_gain_o, 9);
    endtask

    task automatic t_sat();
        run(0, 0, 8'hF8, 8'hF0, 8'hC0, 16'hFFFF, lat);
        chk(aged_gain_o == 65535, "R7 saturation", aged_gain_o, 65535);
        run(0, 0, 8'hF8, 8'hF0, 8'hC0, 16'd0, lat);
        chk(aged_gain_o == 31, "R7 zero cycles", aged_gain_o, 31);
        run(0, 0, 8'hF8, 8'hF0, 8'hC0, 16'd23000, lat);
        chk(aged_gain_o == model(0, 0, 8'hF8, 8'hF0, 8'hC0, 23000), "R7 below limit",
            aged_gain_o, model(0, 0, 8'hF8, 8'hF0, 8'hC0, 23000));
    endtask

    task automatic t_busy();
        int dones;
        longint e;
        e = model(0, 0, 8'h50, 8'h30, 8'h80, 100);
        @(negedge clk);
        fix_dc_i = 0; fix_tc_i = 0; dcomp_i = 8'h50; tcomp_i = 8'h30; agedv_i = 8'h80;
        cycles_i = 16'd100; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        dcomp_i = 8'hF8; tcomp_i = 8'hF0; agedv_i = 8'hC0; cycles_i = 16'hFFFF; fix_dc_i = 1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dones = 0;
        lat = 4;
        for (int i = 0; i < 2 * CYC_W + 6; i++) begin
            @(negedge clk);
            lat++;
            if (done_o) begin
                dones++;
                if (dones == 1) begin
                    chk(aged_gain_o == e, "R9 busy start ignored result", aged_gain_o, e);
                    chk(lat == CYC_W + 1, "R9 busy start latency", lat, CYC_W + 1);
                end
            end
        end
        chk(dones == 1, "R9 single done", dones, 1);
        fix_dc_i = 0;
    endtask

    task automatic t_hold();
        logic [OUT_W-1:0] g;
        logic [7:0] t;
        bit ok;
        run(0, 0, 8'h6B, 8'h50, 8'hC0, 16'd4000, lat);
        g = aged_gain_o;
        t = offset_thr_o;
        chk(t == 96, "R1 threshold code 3", t, 96);
        ok = 1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            dcomp_i = 8'(i * 37); tcomp_i = 8'(i * 19); agedv_i = 8'(i * 53);
            cycles_i = 16'(i * 999); fix_dc_i = i[0]; fix_tc_i = i[1];
            if (aged_gain_o != g || offset_thr_o != t || done_o) ok = 0;
        end
        chk(ok, "R10 outputs held", aged_gain_o, g);
        fix_dc_i = 0; fix_tc_i = 0;
    endtask

    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc_count, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_decode();
        t_basic();
        t_fixdc();
        t_fixtc();
        t_lowbits();
        t_agezero();
        t_sat();
        t_busy();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule